// File: doc/BRIEF.md
# USB Event Interrupt Wrapper

This block gathers per-endpoint transmit and receive events and core-level events (the VBUS-drive event among them) from a USB OTG core into one 32-bit sticky source word. Software reaches it over a simple word-wide register bus. It cannot write the source word or the enable mask directly. Each has a pair of write-one aliases: one sets bits and one clears them. A read-only view returns the enabled, pending sources.

The single interrupt output is a one-cycle pulse. It fires when an enabled source is pending. After it fires it stays blocked until software writes any value to the end-of-interrupt register. A control bit starts a soft clear of the wrapper's state. A revision word identifies the block.

The bus read path is combinational. Writes take effect at the clock edge that samples them. `rstN` is an asynchronous, active-low reset.

Top module: `usb_evt_irq_wrap`

## Requirements
- R1: After reset, every readable register is 0 except the revision word, and `irqOut` is low.
- R2: Offset 0x00 returns the constant `REV_ID`, which is nonzero by default (0x4E1A0102). Writes to it have no effect.
- R3: An event input that is high at a clock edge sets its source bit at that edge. The bit stays set until it is cleared. Positions: `evtTx[i]` → bit i (0..4), `evtRx[i]` → bit 9+i (9..12), `evtCore[i]` → bit 16+i (16..24). `evtCore[8]` is the VBUS-drive event at bit 24. Bit 8 and the other unlisted bits always read 0.
- R4: Writing to offset 0x24 sets the source bits that are 1 in the write data, exactly as an event would. Writing to offset 0x28 clears the source bits that are 1 in the write data. Set bits that fall on unused positions are dropped. Offset 0x20 reads the source word.
- R5: If an event and a source-clear write hit the same bit at the same edge, the bit stays set.
- R6: Writing to offset 0x30 sets mask bits and writing to offset 0x34 clears mask bits, both on valid positions only. Offset 0x2C reads the mask. Direct writes to 0x20 and 0x2C are ignored.
- R7: Offset 0x38 reads the source word ANDed with the mask.
- R8: When the interrupt is armed and a masked source is pending after an edge, `irqOut` is high for exactly one cycle, starting at the next edge. After that the interrupt is blocked, and new sources cause no further pulse.
- R9: A write of any value to offset 0x3C re-arms the interrupt at the edge that samples it. If a masked source is still pending, `irqOut` pulses starting one edge later.
- R10: Writing to offset 0x04 with bit 0 = 1 makes bit 0 of 0x04 read 1 for one cycle. At the next edge the source, the mask, the blocked state and `irqOut` clear, and bit 0 returns to 0. A write with bit 0 = 0 changes nothing.
- R11: Bit 0 of offset 0x08 reflects the `vbusDriveLvl` input. The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte offset of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, combinational from the address |
| evtTx | input | TX_N (5) | Transmit endpoint events |
| evtRx | input | RX_N (4) | Receive endpoint events |
| evtCore | input | CORE_N (9) | Core events, top bit is the VBUS-drive event |
| vbusDriveLvl | input | 1 | Current VBUS-drive level, shown in status |
| irqOut | output | 1 | Interrupt pulse |

## Verification
Every event input is pulsed on its own, so that a misrouted or merged position shows up as a wrong bit in the source word. Each of the 32 bit positions is then written through the set and clear aliases of both the source and the mask. This separates the valid positions from the dropped ones, and also separates the alias paths from the direct-write offsets, which must do nothing. The interrupt is driven through these cases:
- fire, then block against a second event;
- EOI with a source still pending;
- EOI with nothing pending;
- an event racing a clear write on the same bit.

The pulse timing is sampled cycle by cycle, so a late, early or stretched pulse fails. A soft clear is issued with state loaded, and its one-cycle readback and its effect on all three state registers are checked.

// File: rtl/usb_evt_irq_pkg.sv
package usb_evt_irq_pkg;

  localparam logic [7:0] OFS_REV     = 8'h00;
  localparam logic [7:0] OFS_CTRL    = 8'h04;
  localparam logic [7:0] OFS_STAT    = 8'h08;
  localparam logic [7:0] OFS_SRC     = 8'h20;
  localparam logic [7:0] OFS_SRCSET  = 8'h24;
  localparam logic [7:0] OFS_SRCCLR  = 8'h28;
  localparam logic [7:0] OFS_MASK    = 8'h2C;
  localparam logic [7:0] OFS_MASKSET = 8'h30;
  localparam logic [7:0] OFS_MASKCLR = 8'h34;
  localparam logic [7:0] OFS_MASKED  = 8'h38;
  localparam logic [7:0] OFS_EOI     = 8'h3C;

  typedef enum logic [2:0] {
    RS_NONE, RS_REV, RS_CTRL, RS_STAT, RS_SRC, RS_MASK, RS_MASKED
  } rdSel_e;

  typedef struct packed {
    logic   srcSet;
    logic   srcClr;
    logic   maskSet;
    logic   maskClr;
    logic   eoi;
    logic   softClr;
    logic   rstPend;
    rdSel_e rdSel;
  } strobes_t;

  function automatic logic [31:0] fieldBits(input int lsb, input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[lsb + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/usb_evt_irq_ctrl.sv
module usb_evt_irq_ctrl
  import usb_evt_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrBit0,
  output strobes_t          strb
);

  logic wrAcc;
  logic rdAcc;
  logic rstPendQ;

  assign wrAcc = busSel && busWr;
  assign rdAcc = busSel && !busWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPendQ <= 1'b0;
    else       rstPendQ <= wrAcc && (busAddr == ADDR_W'(OFS_CTRL)) && wrBit0;
  end

  always_comb begin
    strb         = '0;
    strb.rdSel   = RS_NONE;
    strb.softClr = rstPendQ;
    strb.rstPend = rstPendQ;
    if (wrAcc) begin
      strb.srcSet  = (busAddr == ADDR_W'(OFS_SRCSET));
      strb.srcClr  = (busAddr == ADDR_W'(OFS_SRCCLR));
      strb.maskSet = (busAddr == ADDR_W'(OFS_MASKSET));
      strb.maskClr = (busAddr == ADDR_W'(OFS_MASKCLR));
      strb.eoi     = (busAddr == ADDR_W'(OFS_EOI));
    end
    if (rdAcc) begin
      unique case (busAddr)
        ADDR_W'(OFS_REV):    strb.rdSel = RS_REV;
        ADDR_W'(OFS_CTRL):   strb.rdSel = RS_CTRL;
        ADDR_W'(OFS_STAT):   strb.rdSel = RS_STAT;
        ADDR_W'(OFS_SRC):    strb.rdSel = RS_SRC;
        ADDR_W'(OFS_MASK):   strb.rdSel = RS_MASK;
        ADDR_W'(OFS_MASKED): strb.rdSel = RS_MASKED;
        default:             strb.rdSel = RS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/usb_evt_irq_dp.sv
module usb_evt_irq_dp
  import usb_evt_irq_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          TX_N     = 5,
  parameter int          RX_N     = 4,
  parameter int          CORE_N   = 9,
  parameter int          TX_LSB   = 0,
  parameter int          RX_LSB   = 9,
  parameter int          CORE_LSB = 16,
  parameter logic [31:0] REV_ID   = 32'h4E1A_0102
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [TX_N-1:0]   evtTx,
  input  logic [RX_N-1:0]   evtRx,
  input  logic [CORE_N-1:0] evtCore,
  input  logic              vbusDriveLvl,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] srcVal,
  output logic [DATA_W-1:0] maskVal,
  output logic              irqOut
);

  localparam logic [31:0] VALID32 = fieldBits(TX_LSB, TX_N)
                                  | fieldBits(RX_LSB, RX_N)
                                  | fieldBits(CORE_LSB, CORE_N);
  localparam logic [DATA_W-1:0] VALID = DATA_W'(VALID32);

  logic [DATA_W-1:0] evtWord;
  logic [DATA_W-1:0] srcQ, maskQ;
  logic [DATA_W-1:0] srcSetBits, srcClrBits, maskSetBits, maskClrBits;
  logic              pending;
  logic              blockedQ;
  logic              irqQ;

  always_comb begin
    evtWord = '0;
    for (int i = 0; i < TX_N; i++)   evtWord[TX_LSB + i]   = evtTx[i];
    for (int i = 0; i < RX_N; i++)   evtWord[RX_LSB + i]   = evtRx[i];
    for (int i = 0; i < CORE_N; i++) evtWord[CORE_LSB + i] = evtCore[i];
  end

  assign srcSetBits  = strb.srcSet  ? busWdata : '0;
  assign srcClrBits  = strb.srcClr  ? busWdata : '0;
  assign maskSetBits = strb.maskSet ? busWdata : '0;
  assign maskClrBits = strb.maskClr ? busWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ  <= '0;
      maskQ <= '0;
    end else if (strb.softClr) begin
      srcQ  <= '0;
      maskQ <= '0;
    end else begin
      srcQ  <= ((srcQ & ~srcClrBits) | srcSetBits | evtWord) & VALID;
      maskQ <= ((maskQ & ~maskClrBits) | maskSetBits) & VALID;
    end
  end

  assign pending = |(srcQ & maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ     <= 1'b0;
      blockedQ <= 1'b0;
    end else if (strb.softClr) begin
      irqQ     <= 1'b0;
      blockedQ <= 1'b0;
    end else if (!blockedQ && pending) begin
      irqQ     <= 1'b1;
      blockedQ <= 1'b1;
    end else begin
      irqQ <= 1'b0;
      if (strb.eoi) blockedQ <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (strb.rdSel)
      RS_REV:    busRdata = DATA_W'(REV_ID);
      RS_CTRL:   busRdata[0] = strb.rstPend;
      RS_STAT:   busRdata[0] = vbusDriveLvl;
      RS_SRC:    busRdata = srcQ;
      RS_MASK:   busRdata = maskQ;
      RS_MASKED: busRdata = srcQ & maskQ;
      default:   busRdata = '0;
    endcase
  end

  assign srcVal  = srcQ;
  assign maskVal = maskQ;
  assign irqOut  = irqQ;

endmodule

// File: rtl/usb_evt_irq_wrap.sv
module usb_evt_irq_wrap
  import usb_evt_irq_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          TX_N     = 5,
  parameter int          RX_N     = 4,
  parameter int          CORE_N   = 9,
  parameter int          TX_LSB   = 0,
  parameter int          RX_LSB   = 9,
  parameter int          CORE_LSB = 16,
  parameter logic [31:0] REV_ID   = 32'h4E1A_0102
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [TX_N-1:0]   evtTx,
  input  logic [RX_N-1:0]   evtRx,
  input  logic [CORE_N-1:0] evtCore,
  input  logic              vbusDriveLvl,
  output logic              irqOut
);

  strobes_t          strb;
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] maskVal;

  usb_evt_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .wrBit0  (busWdata[0]),
    .strb    (strb)
  );

  usb_evt_irq_dp #(
    .DATA_W(DATA_W), .TX_N(TX_N), .RX_N(RX_N), .CORE_N(CORE_N),
    .TX_LSB(TX_LSB), .RX_LSB(RX_LSB), .CORE_LSB(CORE_LSB), .REV_ID(REV_ID)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busWdata     (busWdata),
    .evtTx        (evtTx),
    .evtRx        (evtRx),
    .evtCore      (evtCore),
    .vbusDriveLvl (vbusDriveLvl),
    .busRdata     (busRdata),
    .srcVal       (srcVal),
    .maskVal      (maskVal),
    .irqOut       (irqOut)
  );

endmodule

// File: rtl/usb_evt_irq_chk.sv
module usb_evt_irq_chk #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          VBUS_BIT = 24,
  parameter logic [31:0] REV_ID   = 32'h4E1A_0102
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              vbusEvt,
  input logic [DATA_W-1:0] srcVal,
  input logic [DATA_W-1:0] maskVal,
  input logic              irqOut
);

  logic waitEoi;
  logic clrNext;
  logic eoiWr;
  logic rstWr;

  assign eoiWr = busSel && busWr && (busAddr == ADDR_W'(8'h3C));
  assign rstWr = busSel && busWr && (busAddr == ADDR_W'(8'h04)) && busWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitEoi <= 1'b0;
      clrNext <= 1'b0;
    end else begin
      clrNext <= rstWr;
      if (clrNext)    waitEoi <= 1'b0;
      else if (irqOut) waitEoi <= 1'b1;
      else if (eoiWr)  waitEoi <= 1'b0;
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut); // R8
  AST_NO_REFIRE_BEFORE_EOI: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !waitEoi); // R9
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(srcVal & maskVal) != '0)); // R8
  AST_VBUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (vbusEvt && !clrNext) |=> srcVal[VBUS_BIT]); // R3
  AST_REV_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == ADDR_W'(8'h00)) |-> (busRdata == DATA_W'(REV_ID) && busRdata != '0)); // R2
  AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == ADDR_W'(8'h38)) |-> (busRdata == (srcVal & maskVal))); // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clrNext |=> (srcVal == '0 && maskVal == '0 && !irqOut)); // R10

endmodule

bind usb_evt_irq_wrap usb_evt_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VBUS_BIT(CORE_LSB + CORE_N - 1), .REV_ID(REV_ID)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .vbusEvt  (evtCore[CORE_N-1]),
  .srcVal   (srcVal),
  .maskVal  (maskVal),
  .irqOut   (irqOut)
);

// File: tb/usb_evt_irq_wrap_tb.sv
module usb_evt_irq_wrap_tb_top;

  localparam logic [31:0] REV = 32'h4E1A_0102;
  localparam logic [31:0] VMASK = ((32'd1 << 5) - 1) | (((32'd1 << 4) - 1) << 9)
                                | (((32'd1 << 9) - 1) << 16);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [4:0]  evtTx = '0;
  logic [3:0]  evtRx = '0;
  logic [8:0]  evtCore = '0;
  logic        vbusDriveLvl = 1'b0;
  logic        irqOut;

  int nTests = 0, nFail = 0, irqCnt = 0, wideCnt = 0;
  logic prevIrq = 1'b0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  usb_evt_irq_wrap dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtTx(evtTx), .evtRx(evtRx),
    .evtCore(evtCore), .vbusDriveLvl(vbusDriveLvl), .irqOut(irqOut)
  );

  always @(negedge clk) begin
    if (irqOut) irqCnt++;
    if (irqOut && prevIrq) wideCnt++;
    prevIrq <= irqOut;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic pulseEvt(input int b);
    if (b < 5) evtTx[b] = 1'b1;
    else if (b >= 9 && b < 13) evtRx[b-9] = 1'b1;
    else if (b >= 16 && b < 25) evtCore[b-16] = 1'b1;
    @(negedge clk);
    evtTx = '0; evtRx = '0; evtCore = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=done", 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(8'h20, rv); check("R1 src", rv, 0);
    rd(8'h2C, rv); check("R1 mask", rv, 0);
    rd(8'h04, rv); check("R1 ctrl", rv, 0);
    check("R1 irq", {31'b0, irqOut}, 0);

    // R2: revision constant, write ignored
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, rv); check("R2 rev", rv, REV);

    // R11: status level
    vbusDriveLvl = 1'b1; rd(8'h08, rv); check("R11 stat hi", rv, 1);
    vbusDriveLvl = 1'b0; rd(8'h08, rv); check("R11 stat lo", rv, 0);

    // R3: each event input lands on its own bit
    for (int b = 0; b < 32; b++) begin
      if (VMASK[b]) begin
        pulseEvt(b);
        rd(8'h20, rv); check($sformatf("R3 evt bit %0d", b), rv, 32'd1 << b);
        rd(8'h20, rv); check($sformatf("R3 sticky bit %0d", b), rv, 32'd1 << b);
        wr(8'h28, 32'd1 << b);
      end
    end

    // R4, R6, R7: alias sweep over all positions
    for (int b = 0; b < 32; b++) begin
      wr(8'h24, 32'd1 << b);
      rd(8'h20, rv); check($sformatf("R4 set bit %0d", b), rv, (32'd1 << b) & VMASK);
      wr(8'h30, 32'hFFFF_FFFF);
      wr(8'h34, ~(32'd1 << b));
      rd(8'h2C, rv); check($sformatf("R6 mask bit %0d", b), rv, (32'd1 << b) & VMASK);
      rd(8'h38, rv); check($sformatf("R7 masked bit %0d", b), rv, (32'd1 << b) & VMASK);
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h2C, 32'hFFFF_FFFF);
      rd(8'h20, rv); check($sformatf("R6 direct src bit %0d", b), rv, (32'd1 << b) & VMASK);
      rd(8'h2C, rv); check($sformatf("R6 direct mask bit %0d", b), rv, (32'd1 << b) & VMASK);
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h34, 32'hFFFF_FFFF);
      rd(8'h20, rv); check($sformatf("R4 clr bit %0d", b), rv, 0);
      // irq from this sweep is blocked or cleared; re-arm
      wr(8'h3C, 0);
    end
    repeat (3) @(negedge clk);

    // R8: pulse timing and blocking
    wr(8'h3C, 0);
    repeat (2) @(negedge clk);
    c0 = irqCnt;
    wr(8'h30, 32'h1);
    evtTx[0] = 1'b1; @(negedge clk); evtTx = '0;
    check("R8 not yet", {31'b0, irqOut}, 0);
    @(negedge clk);
    check("R8 pulse", {31'b0, irqOut}, 1);
    @(negedge clk);
    check("R8 one cycle", {31'b0, irqOut}, 0);
    wr(8'h30, 32'h2);
    pulseEvt(1);
    repeat (4) @(negedge clk);
    check("R8 blocked", irqCnt - c0, 1);

    // R9: EOI with pending -> pulse one edge later
    wr(8'h3C, 32'hDEAD_BEEF);
    check("R9 after eoi", {31'b0, irqOut}, 0);
    @(negedge clk);
    check("R9 refire", {31'b0, irqOut}, 1);
    wr(8'h28, 32'h3);
    wr(8'h3C, 0);
    repeat (4) @(negedge clk);
    check("R9 no pending no pulse", irqCnt - c0, 2);

    // R5: event beats clear on the same edge
    wr(8'h24, 32'h2);
    evtTx[1] = 1'b1;
    wr(8'h28, 32'h2);
    evtTx = '0;
    rd(8'h20, rv); check("R5 event wins", rv, 32'h2);

    // R10: soft clear with state loaded
    wr(8'h24, 32'h0100_0001);
    wr(8'h04, 32'h0);
    rd(8'h20, rv); check("R10 bit0 zero no effect", rv, 32'h0100_0003);
    wr(8'h04, 32'h1);
    rd(8'h04, rv); check("R10 ctrl readback", rv, 1);
    rd(8'h04, rv); check("R10 ctrl self clear", rv, 0);
    rd(8'h20, rv); check("R10 src cleared", rv, 0);
    rd(8'h2C, rv); check("R10 mask cleared", rv, 0);
    c0 = irqCnt;
    wr(8'h30, 32'h1);
    pulseEvt(0);
    repeat (3) @(negedge clk);
    check("R10 rearmed", irqCnt - c0, 1);

    check("R8 width", wideCnt, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule